// File: doc/BRIEF.md
# SMI Fan-out Controller with Feature Lock

This block turns writes to a power-management command port into system-management interrupt requests. It also runs a one-time feature handshake with firmware. The host side fixes a 64-bit mask of supported features at build time. The guest then proceeds in three steps:

1. It fills a 64-bit request register one byte at a time, least significant byte at byte index 0.
2. It pulses a commit strobe.
3. If the request asks only for supported features, the request is latched as the negotiated set and a success flag rises. From then on the negotiated set cannot change until reset.

Feature bit 0 of the negotiated set selects broadcast delivery. When it is set, an interrupt-raising command pulses every CPU's SMI line. When it is clear, only the line of the CPU that issued the command pulses. Two command codes are reserved for ACPI mode switching: 0xF1 enables ACPI and 0xF0 disables it. These two codes produce a one-cycle ACPI enable or disable pulse and never an SMI. Every other code raises an SMI only while the command-port enable bit is set.

Top module: `smi_negotiate_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `featOk`, `negotiated`, `smiPulse`, `acpiEnPulse` and `acpiDisPulse` are all zero.
- R2: A request byte written at index i (0 to 7) occupies bits 8i+7 down to 8i of the 64-bit request. A successful commit makes this assembled value visible on `negotiated`.
- R3: A commit whose request has no bit outside `HOST_MASK` sets `featOk` and loads `negotiated` with the request in the cycle after the strobe.
- R4: A commit whose request has any bit outside `HOST_MASK` leaves `featOk` at 0 and `negotiated` unchanged.
- R5: Once `featOk` is 1, further commits and byte writes leave `negotiated` and `featOk` unchanged until reset.
- R6: Command 0xF1 gives a one-cycle `acpiEnPulse` and command 0xF0 gives a one-cycle `acpiDisPulse`. Neither code ever pulses any `smiPulse` bit, whatever the enable input.
- R7: Any other command written while `apmSmiEn` is 0 leaves `smiPulse` at zero.
- R8: Any other command written while `apmSmiEn` is 1 and negotiated bit 0 is 0 pulses only `smiPulse[apmCpu]`.
- R9: Any other command written while `apmSmiEn` is 1 and negotiated bit 0 is 1 pulses every bit of `smiPulse`.
- R10: All pulse outputs last exactly one cycle per command write.
- R11: Reset clears the stored request bytes. A commit right after reset therefore succeeds with `negotiated` equal to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqByteWe | input | 1 | Write one byte of the request mask |
| reqByteIdx | input | 3 | Byte index, 0 = least significant |
| reqByteData | input | 8 | Byte value |
| commitStb | input | 1 | Attempt to lock the request |
| apmWe | input | 1 | Command-port write strobe |
| apmCmd | input | 8 | Command code |
| apmCpu | input | CPU_IDX_W | Index of the writing CPU |
| apmSmiEn | input | 1 | Command-port SMI enable bit |
| smiPulse | output | NUM_CPUS | Per-CPU SMI pulse |
| acpiEnPulse | output | 1 | ACPI enable pulse |
| acpiDisPulse | output | 1 | ACPI disable pulse |
| featOk | output | 1 | Negotiation succeeded |
| negotiated | output | 64 | Locked feature set |

## Verification
Every result is registered once, so each output answers the stimulus of the previous clock edge exactly one cycle later. The bench drives inputs on the falling edge and checks on the next falling edge, after that single register stage. Its model follows the same ordering as the hardware: a commit tests the request bytes as they stood before the edge, and an SMI issued in the same cycle as a commit uses the old broadcast bit. A second sample one cycle on confirms that the pulses have dropped.

// File: rtl/smi_neg_pkg.sv
package smi_neg_pkg;
  localparam logic [7:0] CMD_ACPI_ON  = 8'hF1;
  localparam logic [7:0] CMD_ACPI_OFF = 8'hF0;
  localparam int         BCAST_BIT    = 0;

  typedef struct packed {
    logic acpiEn;
    logic acpiDis;
    logic smiReq;
    logic commit;
  } ctlStrobes_t;
endpackage

// File: rtl/smi_neg_control.sv
module smi_neg_control
  import smi_neg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        apmWe,
  input  logic [7:0]  apmCmd,
  input  logic        apmSmiEn,
  input  logic        commitStb,
  output ctlStrobes_t strb
);
  logic isOn, isOff;

  always_comb begin
    isOn        = (apmCmd == CMD_ACPI_ON);
    isOff       = (apmCmd == CMD_ACPI_OFF);
    strb.acpiEn  = apmWe && isOn;
    strb.acpiDis = apmWe && isOff;
    strb.smiReq  = apmWe && !isOn && !isOff && apmSmiEn;
    strb.commit  = commitStb;
  end

  // R7: an SMI request never appears without a command write and the enable
  a_r7_smi_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    strb.smiReq |-> (apmWe && apmSmiEn));
endmodule

// File: rtl/smi_neg_datapath.sv
module smi_neg_datapath
  import smi_neg_pkg::*;
#(
  parameter int          NUM_CPUS  = 4,
  parameter logic [63:0] HOST_MASK = 64'h8000_0100_0000_0005,
  localparam int         CPU_IDX_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
  localparam int         NUM_BYTES = 8
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobes_t          strb,
  input  logic                 reqByteWe,
  input  logic [2:0]           reqByteIdx,
  input  logic [7:0]           reqByteData,
  input  logic [CPU_IDX_W-1:0] apmCpu,
  output logic [NUM_CPUS-1:0]  smiPulse,
  output logic                 acpiEnPulse,
  output logic                 acpiDisPulse,
  output logic                 featOk,
  output logic [63:0]          negotiated
);
  logic [NUM_BYTES-1:0][7:0] reqBytes;
  logic [63:0]               reqWord;
  logic [NUM_CPUS-1:0]       selOne;
  logic                      reqValid;

  assign reqWord  = reqBytes;
  assign reqValid = ((reqWord & ~HOST_MASK) == 64'd0);

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rstN)
        reqBytes[b] <= 8'd0;
      else if (reqByteWe && (reqByteIdx == 3'(b)))
        reqBytes[b] <= reqByteData;
    end
  end

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    assign selOne[c] = (apmCpu == CPU_IDX_W'(c));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      featOk       <= 1'b0;
      negotiated   <= 64'd0;
      smiPulse     <= '0;
      acpiEnPulse  <= 1'b0;
      acpiDisPulse <= 1'b0;
    end else begin
      if (strb.commit && !featOk && reqValid) begin
        negotiated <= reqWord;
        featOk     <= 1'b1;
      end
      acpiEnPulse  <= strb.acpiEn;
      acpiDisPulse <= strb.acpiDis;
      if (strb.smiReq)
        smiPulse <= negotiated[BCAST_BIT] ? '1 : selOne;
      else
        smiPulse <= '0;
    end
  end

  a_r5_locked: assert property (@(posedge clk) disable iff (!rstN)
    featOk |=> (featOk && $stable(negotiated)));
  a_r4_subset_only: assert property (@(posedge clk) disable iff (!rstN)
    featOk |-> ((negotiated & ~HOST_MASK) == 64'd0));
  a_r6_no_smi_with_acpi: assert property (@(posedge clk) disable iff (!rstN)
    (acpiEnPulse || acpiDisPulse) |-> (smiPulse == '0));
  a_r8_single_target: assert property (@(posedge clk) disable iff (!rstN)
    !negotiated[BCAST_BIT] |=> $onehot0(smiPulse));
  a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (acpiEnPulse && !$past(strb.acpiEn, 1) ) |-> 1'b0);
endmodule

// File: rtl/smi_negotiate_top.sv
module smi_negotiate_top
  import smi_neg_pkg::*;
#(
  parameter int          NUM_CPUS  = 4,
  parameter logic [63:0] HOST_MASK = 64'h8000_0100_0000_0005,
  localparam int         CPU_IDX_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqByteWe,
  input  logic [2:0]           reqByteIdx,
  input  logic [7:0]           reqByteData,
  input  logic                 commitStb,
  input  logic                 apmWe,
  input  logic [7:0]           apmCmd,
  input  logic [CPU_IDX_W-1:0] apmCpu,
  input  logic                 apmSmiEn,
  output logic [NUM_CPUS-1:0]  smiPulse,
  output logic                 acpiEnPulse,
  output logic                 acpiDisPulse,
  output logic                 featOk,
  output logic [63:0]          negotiated
);
  ctlStrobes_t strb;

  smi_neg_control i_ctl (
    .clk(clk), .rstN(rstN), .apmWe(apmWe), .apmCmd(apmCmd),
    .apmSmiEn(apmSmiEn), .commitStb(commitStb), .strb(strb)
  );

  smi_neg_datapath #(.NUM_CPUS(NUM_CPUS), .HOST_MASK(HOST_MASK)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .reqByteWe(reqByteWe), .reqByteIdx(reqByteIdx), .reqByteData(reqByteData),
    .apmCpu(apmCpu), .smiPulse(smiPulse), .acpiEnPulse(acpiEnPulse),
    .acpiDisPulse(acpiDisPulse), .featOk(featOk), .negotiated(negotiated)
  );
endmodule

// File: tb/test_smi_negotiate_top.sv
module test_smi_negotiate_top;
  localparam int          PERIOD = 10;
  localparam int          NCPU   = 4;
  localparam logic [63:0] HOST   = 64'h8000_0100_0000_0005;

  logic clk = 0, rstN = 0;
  logic reqByteWe = 0, commitStb = 0, apmWe = 0, apmSmiEn = 0;
  logic [2:0] reqByteIdx = 0;
  logic [7:0] reqByteData = 0, apmCmd = 0;
  logic [1:0] apmCpu = 0;
  logic [NCPU-1:0] smiPulse;
  logic acpiEnPulse, acpiDisPulse, featOk;
  logic [63:0] negotiated;

  int nChk = 0, nFail = 0;
  logic [63:0] reqM, negM;
  logic okM;

  always #(PERIOD/2) clk = ~clk;

  smi_negotiate_top #(.NUM_CPUS(NCPU), .HOST_MASK(HOST)) i_smi_negotiate_top (.*);

  function automatic logic [NCPU-1:0] expSmi(logic we, logic [7:0] cmd, logic en,
                                             logic [1:0] cpu, logic [63:0] neg);
    if (!we || cmd == 8'hF1 || cmd == 8'hF0 || !en) return '0;
    return neg[0] ? '1 : NCPU'(1) << cpu;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 0;
    @(negedge clk);
    rstN = 1;
    reqM = 0; negM = 0; okM = 0;
  endtask

  // one clock: drive at a falling edge, check at the next one
  task automatic cyc(logic we, logic [2:0] idx, logic [7:0] dat, logic cm,
                     logic aw, logic [7:0] cmd, logic [1:0] cpu, logic en, string tag);
    logic [NCPU-1:0] eSmi;
    reqByteWe = we; reqByteIdx = idx; reqByteData = dat; commitStb = cm;
    apmWe = aw; apmCmd = cmd; apmCpu = cpu; apmSmiEn = en;
    eSmi = expSmi(aw, cmd, en, cpu, negM);
    if (cm && !okM && ((reqM & ~HOST) == 0)) begin negM = reqM; okM = 1; end
    if (we) reqM[idx*8 +: 8] = dat;
    @(negedge clk);
    reqByteWe = 0; commitStb = 0; apmWe = 0;
    chk({tag, " featOk"}, 64'(featOk), 64'(okM));
    chk({tag, " negotiated"}, negotiated, negM);
    chk({tag, " smi"}, 64'(smiPulse), 64'(eSmi));
    chk({tag, " acpiEn"}, 64'(acpiEnPulse), 64'(aw && cmd == 8'hF1));
    chk({tag, " acpiDis"}, 64'(acpiDisPulse), 64'(aw && cmd == 8'hF0));
  endtask

  task automatic idle(string tag);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(PERIOD * 200000);
    nChk++; nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    reqM = 0; negM = 0; okM = 0;
    @(negedge clk);
    chk("R1 reset featOk", 64'(featOk), 0);
    chk("R1 reset negotiated", negotiated, 0);
    chk("R1 reset smi", 64'(smiPulse), 0);
    doReset();
    idle("R1 after reset");
    // R7: SMI disabled
    cyc(0, 0, 0, 0, 1, 8'h42, 2, 0, "R7");
    // R8: current CPU only
    cyc(0, 0, 0, 0, 1, 8'h42, 2, 1, "R8");
    idle("R10 drop");
    // R4: bit1 outside host mask
    cyc(1, 0, 8'h02, 0, 0, 0, 0, 0, "R4 write");
    cyc(0, 0, 0, 1, 0, 0, 0, 0, "R4 commit");
    // R2 + R3: multi-byte request, little-endian
    cyc(1, 0, 8'h01, 0, 0, 0, 0, 0, "R2 b0");
    cyc(1, 5, 8'h01, 0, 0, 0, 0, 0, "R2 b5");
    cyc(1, 7, 8'h80, 0, 0, 0, 0, 0, "R2 b7");
    cyc(0, 0, 0, 1, 1, 8'h11, 1, 1, "R3 commit");
    chk("R2 assembled", negotiated, 64'h8000_0100_0000_0001);
    // R9: broadcast
    cyc(0, 0, 0, 0, 1, 8'h11, 3, 1, "R9");
    idle("R10 drop bcast");
    // R5: relock ignored
    cyc(1, 0, 8'h04, 0, 0, 0, 0, 0, "R5 write");
    cyc(0, 0, 0, 1, 0, 0, 0, 0, "R5 commit");
    // R6: ACPI codes
    cyc(0, 0, 0, 0, 1, 8'hF1, 0, 1, "R6 on");
    cyc(0, 0, 0, 0, 1, 8'hF0, 1, 1, "R6 off");
    idle("R10 drop acpi");
    // R11: reset clears request bytes
    doReset();
    idle("R11 after reset");
    cyc(0, 0, 0, 1, 0, 0, 0, 0, "R11 commit");
    chk("R11 negotiated zero", negotiated, 0);
    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] rb, rc;
      if ((n % 60) == 0) doReset();
      rb = 8'($urandom);
      if ($urandom_range(0, 3) != 0) rb = rb & HOST[($urandom_range(0,7)*8) +: 8];
      rc = ($urandom_range(0, 4) == 0) ? 8'hF0 + 8'($urandom_range(0, 1)) : 8'($urandom);
      cyc($urandom_range(0, 1) == 1, 3'($urandom), rb, $urandom_range(0, 7) == 0,
          $urandom_range(0, 1) == 1, rc, 2'($urandom), $urandom_range(0, 3) != 0,
          "R3/R8/R9 random");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule